// File: doc/BRIEF.md
# Power-Gating Sequencer with Isolation Clamps

This block orders the shutdown and wake-up of a single switchable power domain and guards every signal that leaves that domain for the always-on side. A shutdown request first closes the isolation clamps. The sequencer then holds for a run-time count of cycles and only after that opens the power switch. A wake-up request closes the switch again, waits until the switch reports power-good, lets a second run-time count elapse, and only then opens the clamps.

Each crossing bit has a clamp value that is fixed when the block is elaborated through a mask parameter. A mask bit of 0 builds an AND with the active-low isolation enable, so the bit is forced to 0. A mask bit of 1 builds an OR with the inverted enable, so the bit is forced to 1. When isolation is off, every clamp passes its input straight through. The clamp path is purely combinational and carries a plain level, so it has no valid/ready handshake. All control and status pins are plain levels.

Top module: `pgate_seq`

## Requirements
- R1: After reset the switch enable `sw_en` is 1, `iso_n` is 1, `busy` is 0 and `state_o` is 0 (powered-on state).
- R2: A `req_down` sampled in state 0 moves the block on that edge to state 1 (isolating), with `iso_n`=0, `sw_en`=1 and `busy`=1. Exactly `iso_lead`+1 edges later the block enters state 2 (off), with `sw_en`=0 and `busy`=0.
- R3: `iso_n` is 0 in every cycle in which `sw_en` is 0, and `iso_n` has already been 0 for at least one cycle when `sw_en` falls.
- R4: A `req_up` sampled in state 2 moves the block on that edge to state 3 (powering up), with `sw_en`=1, `busy`=1 and `iso_n` still 0.
- R5: In state 3, the first edge that samples `pwr_good` high starts the settle count. The block enters state 0 with `iso_n`=1 exactly `settle`+1 edges after that edge.
- R6: While `pwr_good` stays low in state 3, the block stays in state 3 with isolation asserted.
- R7: `req_down` has no effect outside state 0, and `req_up` has no effect outside state 2.
- R8: An output bit whose `CLAMP_MASK` bit is 0 equals `dom_out & iso_n`, so it reads 0 while isolated.
- R9: An output bit whose `CLAMP_MASK` bit is 1 equals `dom_out | ~iso_n`, so it reads 1 while isolated.
- R10: With `iso_n`=1, `clamp_out` equals `dom_out`.
- R11: While the switch is off, `clamp_out` equals `CLAMP_MASK` whatever `dom_out` carries, including unknown values.
- R12: `busy` is 1 exactly in states 1 and 3.
- R13: With `iso_lead`=0 the isolating state lasts one cycle. With `settle`=0 the block reaches state 0 on the edge after `pwr_good` is first seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_down | input | 1 | Shutdown request, level sampled each edge |
| req_up | input | 1 | Wake-up request, level sampled each edge |
| pwr_good | input | 1 | Power-good acknowledge from the switch |
| iso_lead | input | CW | Extra cycles between isolation and switch-off |
| settle | input | CW | Extra cycles between power-good and isolation release |
| dom_out | input | W | Raw outputs of the switchable domain |
| sw_en | output | 1 | Power switch enable, 1 = domain powered |
| iso_n | output | 1 | Isolation enable, active low |
| clamp_out | output | W | Clamped signals toward the always-on domain |
| busy | output | 1 | High in the transitional states |
| state_o | output | 2 | Sequencer state: 0 on, 1 isolating, 2 off, 3 powering up |

## Verification
The bench builds the block with W=8, CW=4 and CLAMP_MASK=8'hA5, so the mask holds both clamp-to-0 and clamp-to-1 bits in alternating groups. This lets R8 and R9 be checked in the same output word. The bench drives `iso_lead` and `settle` at run time. It first uses 2 and 1, which exposes the exact counting of the waiting windows. It then uses 0 and 0, which reaches the shortest legal sequences of R13. Requests are also driven in every state where they must be ignored, and `pwr_good` is held low for several cycles during power-up.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
  typedef enum logic [1:0] {
    ST_ON  = 2'd0,
    ST_ISO = 2'd1,
    ST_OFF = 2'd2,
    ST_UP  = 2'd3
  } pg_state_e;
endpackage

// File: rtl/pgate_cnt.sv
module pgate_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (dec && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pgate_fsm.sv
module pgate_fsm
  import pgate_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_down,
  input  logic          req_up,
  input  logic          pwr_good,
  input  logic [CW-1:0] iso_lead,
  input  logic [CW-1:0] settle,
  input  logic          cnt_zero,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output logic          cnt_dec,
  output pg_state_e     state,
  output logic          sw_en,
  output logic          iso_n,
  output logic          busy
);
  pg_state_e state_q, state_d;
  logic      good_q, good_d;
  logic      sw_q, iso_q;

  always_comb begin
    state_d  = state_q;
    good_d   = good_q;
    cnt_load = 1'b0;
    cnt_val  = iso_lead;
    cnt_dec  = 1'b0;
    unique case (state_q)
      ST_ON: begin
        if (req_down) begin
          state_d  = ST_ISO;
          cnt_load = 1'b1;
          cnt_val  = iso_lead;
        end
      end
      ST_ISO: begin
        if (cnt_zero) state_d = ST_OFF;
        else          cnt_dec = 1'b1;
      end
      ST_OFF: begin
        if (req_up) begin
          state_d = ST_UP;
          good_d  = 1'b0;
        end
      end
      ST_UP: begin
        if (!good_q) begin
          if (pwr_good) begin
            good_d   = 1'b1;
            cnt_load = 1'b1;
            cnt_val  = settle;
          end
        end else if (cnt_zero) begin
          state_d = ST_ON;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      default: state_d = ST_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ON;
      good_q  <= 1'b0;
      sw_q    <= 1'b1;
      iso_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      good_q  <= good_d;
      sw_q    <= (state_d != ST_OFF);
      iso_q   <= (state_d == ST_ON);
    end
  end

  assign state = state_q;
  assign sw_en = sw_q;
  assign iso_n = iso_q;
  assign busy  = (state_q == ST_ISO) || (state_q == ST_UP);

  assert_iso_before_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_en) |-> (!iso_n && !$past(iso_n)));
  assert_off_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |-> !iso_n);
  assert_release_after_good_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iso_n) |-> ($past(state_q) == ST_UP && $past(good_q)));
  assert_wake_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> !iso_n);
  assert_idle_consistent_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (iso_n == sw_en));
  assert_leave_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_OFF && state_q != ST_OFF) |-> (state_q == ST_UP && $past(req_up)));
  assert_leave_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_ON && state_q != ST_ON) |-> (state_q == ST_ISO && $past(req_down)));
endmodule

// File: rtl/pgate_clamp_bank.sv
module pgate_clamp_bank #(
  parameter int         W          = 8,
  parameter logic [W-1:0] CLAMP_MASK = '0
) (
  input  logic         iso_n,
  input  logic [W-1:0] src,
  output logic [W-1:0] dst
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (CLAMP_MASK[i]) begin : g_hi
      assign dst[i] = src[i] | ~iso_n;
    end else begin : g_lo
      assign dst[i] = src[i] & iso_n;
    end
  end
endmodule

// File: rtl/pgate_seq.sv
module pgate_seq
  import pgate_pkg::*;
#(
  parameter int           W          = 8,
  parameter int           CW         = 4,
  parameter logic [W-1:0] CLAMP_MASK = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_down,
  input  logic          req_up,
  input  logic          pwr_good,
  input  logic [CW-1:0] iso_lead,
  input  logic [CW-1:0] settle,
  input  logic [W-1:0]  dom_out,
  output logic          sw_en,
  output logic          iso_n,
  output logic [W-1:0]  clamp_out,
  output logic          busy,
  output logic [1:0]    state_o
);
  logic          cnt_load, cnt_dec, cnt_zero;
  logic [CW-1:0] cnt_val;
  pg_state_e     state;

  pgate_fsm #(.CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_down(req_down), .req_up(req_up),
    .pwr_good(pwr_good), .iso_lead(iso_lead), .settle(settle),
    .cnt_zero(cnt_zero), .cnt_load(cnt_load), .cnt_val(cnt_val),
    .cnt_dec(cnt_dec), .state(state), .sw_en(sw_en), .iso_n(iso_n),
    .busy(busy)
  );

  pgate_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .zero(cnt_zero)
  );

  pgate_clamp_bank #(.W(W), .CLAMP_MASK(CLAMP_MASK)) u_clamp (
    .iso_n(iso_n), .src(dom_out), .dst(clamp_out)
  );

  assign state_o = state;

  assert_off_clamped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |-> (clamp_out === CLAMP_MASK));
endmodule

// File: tb/pgate_seq_tb.sv
module pgate_seq_tb;
  localparam int           W    = 8;
  localparam int           CW   = 4;
  localparam logic [W-1:0] MASK = 8'hA5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_down = 1'b0, req_up = 1'b0, pwr_good = 1'b0;
  logic [CW-1:0] iso_lead = '0, settle = '0;
  logic [W-1:0]  dom_out = '0;
  logic          sw_en, iso_n, busy;
  logic [W-1:0]  clamp_out;
  logic [1:0]    state_o;

  always #5 clk = ~clk;

  pgate_seq #(.W(W), .CW(CW), .CLAMP_MASK(MASK)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_down(req_down), .req_up(req_up),
    .pwr_good(pwr_good), .iso_lead(iso_lead), .settle(settle),
    .dom_out(dom_out), .sw_en(sw_en), .iso_n(iso_n),
    .clamp_out(clamp_out), .busy(busy), .state_o(state_o)
  );

  typedef struct {
    logic         sw, iso, bsy;
    logic [1:0]   st;
    logic [W-1:0] out;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0, fails = 0, cycles = 0;
  bit   done = 1'b0;

  // Drive inputs for one cycle and queue the expected post-edge outputs.
  task automatic cyc(input logic rd, input logic ru, input logic pg,
                     input logic [W-1:0] dom, input logic esw, input logic eiso,
                     input logic ebusy, input logic [1:0] est, input string tag);
    exp_t e;
    @(negedge clk);
    req_down = rd; req_up = ru; pwr_good = pg; dom_out = dom;
    e.sw = esw; e.iso = eiso; e.bsy = ebusy; e.st = est; e.tag = tag;
    e.out = eiso ? dom : MASK;
    exp_q.push_back(e);
  endtask

  // Monitor: compare outputs 3 ns after each rising edge.
  always @(posedge clk) begin
    #3;
    cycles++;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (sw_en !== e.sw || iso_n !== e.iso || busy !== e.bsy ||
          state_o !== e.st || clamp_out !== e.out) begin
        fails++;
        $display("FAIL %s: got sw=%b iso_n=%b busy=%b st=%0d out=%h, expected sw=%b iso_n=%b busy=%b st=%0d out=%h",
                 e.tag, sw_en, iso_n, busy, state_o, clamp_out,
                 e.sw, e.iso, e.bsy, e.st, e.out);
      end
    end
  end

  initial begin
    // R1: reset state
    cyc(0, 0, 0, 8'h00, 1, 1, 0, 2'd0, "R1");
    cyc(0, 0, 0, 8'h00, 1, 1, 0, 2'd0, "R1");
    @(negedge clk); rst_n = 1'b1;
    iso_lead = 4'd2; settle = 4'd1;
    cyc(0, 0, 0, 8'h3C, 1, 1, 0, 2'd0, "R10");
    cyc(0, 1, 0, 8'hC3, 1, 1, 0, 2'd0, "R7");       // req_up ignored in ON
    cyc(1, 0, 0, 8'hFF, 1, 0, 1, 2'd1, "R2");       // enter isolating
    cyc(1, 0, 0, 8'h00, 1, 0, 1, 2'd1, "R7");       // req_down ignored
    cyc(0, 0, 0, 8'hFF, 1, 0, 1, 2'd1, "R3");       // still powered, isolated
    cyc(0, 0, 0, 8'h5A, 0, 0, 0, 2'd2, "R2");       // off after lead+1 edges
    cyc(0, 0, 0, 8'hFF, 0, 0, 0, 2'd2, "R9");
    cyc(0, 0, 0, 8'h00, 0, 0, 0, 2'd2, "R8");
    cyc(1, 0, 1, 8'h77, 0, 0, 0, 2'd2, "R7");       // req_down ignored in OFF
    cyc(0, 1, 1, 8'h12, 1, 0, 1, 2'd3, "R4");       // power-up entry
    cyc(0, 0, 0, 8'h34, 1, 0, 1, 2'd3, "R6");
    cyc(1, 0, 0, 8'h56, 1, 0, 1, 2'd3, "R6");       // req_down ignored too
    cyc(0, 1, 0, 8'h78, 1, 0, 1, 2'd3, "R12");
    cyc(0, 0, 1, 8'h9A, 1, 0, 1, 2'd3, "R5");       // power-good seen
    cyc(0, 0, 0, 8'hBC, 1, 0, 1, 2'd3, "R5");       // settling
    cyc(0, 0, 0, 8'hDE, 1, 1, 0, 2'd0, "R5");       // released
    cyc(0, 0, 0, 8'h5A, 1, 1, 0, 2'd0, "R10");
    // shortest windows
    iso_lead = 4'd0; settle = 4'd0;
    cyc(1, 0, 0, 8'hF0, 1, 0, 1, 2'd1, "R13");
    cyc(0, 0, 0, 8'h0F, 0, 0, 0, 2'd2, "R13");
    cyc(0, 0, 0, 8'hxx, 0, 0, 0, 2'd2, "R11");      // unknown domain data
    cyc(0, 1, 0, 8'h00, 1, 0, 1, 2'd3, "R4");
    cyc(0, 0, 1, 8'h00, 1, 0, 1, 2'd3, "R13");
    cyc(0, 0, 1, 8'hA5, 1, 1, 0, 2'd0, "R13");
    cyc(0, 0, 0, 8'h5A, 1, 1, 0, 2'd0, "R12");
    wait (exp_q.size() == 0);
    @(posedge clk); #4;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule